// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in front of the ALU of an in-order pipeline with five stages. Each operand of the instruction in execute may depend on a result that has not reached the register file yet. Two older instructions can hold such a result: the one just past execute (the near producer) and the one about to retire (the far producer).

For each of the two operands the block compares the source register number with the destination of each producer. It emits a 2-bit select code and drives the chosen value out of a 3-way multiplexer. The three inputs are the register-file read value, the near producer's ALU result and the far producer's result.

When both producers target the register an operand reads, the near one holds the newer value and wins. Register zero is never forwarded. A producer whose write-enable is low is never forwarded, whatever its destination field holds. The block has no state and no clock: its outputs follow its inputs in the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: When the near producer writes (near_wr_i=1) to a nonzero register equal to an operand's source, that operand's select is 2'b10 and the operand output equals near_val_i.
- R2: When only the far producer writes (far_wr_i=1) to a nonzero register equal to an operand's source, that operand's select is 2'b01 and the operand output equals far_val_i.
- R3: When both producers write the same nonzero register that an operand reads, the select is 2'b10 and the near value is delivered. For example, three back-to-back adds on one register give the third add the second add's result.
- R4: A producer whose destination is register 0 is never forwarded, whatever its write-enable. An operand reading register 0 gets select 2'b00.
- R5: A producer with its write-enable low is never forwarded, even when its destination matches the source.
- R6: With no qualifying producer, the select is 2'b00 and the operand output equals that operand's register-file input. This includes the state with all producers idle.
- R7: The two operands are decided independently. When both read the same register, both selects and both operand outputs are identical.
- R8: The select code 2'b11 is never produced. The multiplexer treats 2'b11 like 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_src_i | input | RW | Source register number of operand A |
| op_b_src_i | input | RW | Source register number of operand B |
| op_a_file_i | input | DW | Register-file read value for operand A |
| op_b_file_i | input | DW | Register-file read value for operand B |
| near_dst_i | input | RW | Destination register of the near producer |
| near_wr_i | input | 1 | Near producer writes a register |
| near_val_i | input | DW | ALU result held by the near producer |
| far_dst_i | input | RW | Destination register of the far producer |
| far_wr_i | input | 1 | Far producer writes a register |
| far_val_i | input | DW | Result held by the far producer |
| op_a_sel_o | output | 2 | Select code for operand A (00 file, 01 far, 10 near) |
| op_b_sel_o | output | 2 | Select code for operand B |
| op_a_o | output | DW | Forwarded operand A |
| op_b_o | output | DW | Forwarded operand B |

## Verification
The bench models the pipeline instruction by instruction. Its expected operands come from an architectural register file that is updated as soon as each instruction's result is known. Any wrong select therefore shows up as a value mismatch, and all results are kept distinct.

Directed patterns cover several cases:
- three dependent adds on one register, which separates the near producer from the far one;
- a bubble between producer and consumer, which exercises the far path alone;
- producers aimed at register 0, and matching producers with write-enable low;
- the two operands fed from different stages at once.

A long pseudo-random stream over eight registers then mixes these cases. In that stream the two operands often read the same register.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_FILE = 2'b00,
        SEL_FAR  = 2'b01,
        SEL_NEAR = 2'b10,
        SEL_RSV  = 2'b11
    } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src_i,
    input  logic [RW-1:0] dst_i,
    input  logic          wr_i,
    output logic          hit_o
);
    // a producer qualifies only if it writes, targets a real register and matches
    always_comb begin
        hit_o = wr_i && (dst_i != '0) && (dst_i == src_i);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic     near_hit_i,
    input  logic     far_hit_i,
    output fwd_sel_e sel_o
);
    // newer result takes priority; the far path is suppressed by a near hit
    always_comb begin
        if (near_hit_i)      sel_o = SEL_NEAR;
        else if (far_hit_i)  sel_o = SEL_FAR;
        else                 sel_o = SEL_FILE;
    end

    always_comb begin
        if (!$isunknown({near_hit_i, far_hit_i})) begin
            p_sel_legal_r8: assert (sel_o != SEL_RSV)
                else $error("reserved select produced");
        end
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  fwd_sel_e      sel_i,
    input  logic [DW-1:0] file_i,
    input  logic [DW-1:0] near_i,
    input  logic [DW-1:0] far_i,
    output logic [DW-1:0] y_o
);
    always_comb begin
        case (sel_i)
            SEL_NEAR: y_o = near_i;
            SEL_FAR:  y_o = far_i;
            default:  y_o = file_i;   // SEL_FILE and the reserved code
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int RW = 5,
    parameter int DW = 32
) (
    input  logic [RW-1:0] op_a_src_i,
    input  logic [RW-1:0] op_b_src_i,
    input  logic [DW-1:0] op_a_file_i,
    input  logic [DW-1:0] op_b_file_i,
    input  logic [RW-1:0] near_dst_i,
    input  logic          near_wr_i,
    input  logic [DW-1:0] near_val_i,
    input  logic [RW-1:0] far_dst_i,
    input  logic          far_wr_i,
    input  logic [DW-1:0] far_val_i,
    output logic [1:0]    op_a_sel_o,
    output logic [1:0]    op_b_sel_o,
    output logic [DW-1:0] op_a_o,
    output logic [DW-1:0] op_b_o
);
    localparam int NOPS = 2;

    logic [RW-1:0] src  [NOPS];
    logic [DW-1:0] file [NOPS];
    fwd_sel_e      sel  [NOPS];
    logic [DW-1:0] opnd [NOPS];

    assign src[0]  = op_a_src_i;
    assign src[1]  = op_b_src_i;
    assign file[0] = op_a_file_i;
    assign file[1] = op_b_file_i;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        logic near_hit;
        logic far_hit;

        fwd_match #(.RW(RW)) u_near (
            .src_i (src[g]),
            .dst_i (near_dst_i),
            .wr_i  (near_wr_i),
            .hit_o (near_hit)
        );

        fwd_match #(.RW(RW)) u_far (
            .src_i (src[g]),
            .dst_i (far_dst_i),
            .wr_i  (far_wr_i),
            .hit_o (far_hit)
        );

        fwd_pick u_pick (
            .near_hit_i (near_hit),
            .far_hit_i  (far_hit),
            .sel_o      (sel[g])
        );

        fwd_opmux #(.DW(DW)) u_mux (
            .sel_i  (sel[g]),
            .file_i (file[g]),
            .near_i (near_val_i),
            .far_i  (far_val_i),
            .y_o    (opnd[g])
        );

        always_comb begin
            if (!$isunknown({src[g], file[g], near_dst_i, near_wr_i, near_val_i,
                             far_dst_i, far_wr_i, far_val_i})) begin
                p_near_data_r1: assert (sel[g] != SEL_NEAR || opnd[g] == near_val_i)
                    else $error("near select without near data");
                p_far_data_r2: assert (sel[g] != SEL_FAR || opnd[g] == far_val_i)
                    else $error("far select without far data");
                p_newest_wins_r3: assert (!(near_wr_i && near_dst_i == src[g] && src[g] != '0)
                                          || sel[g] == SEL_NEAR)
                    else $error("older result chosen over newer");
                p_zero_never_r4: assert (src[g] != '0 || sel[g] == SEL_FILE)
                    else $error("register zero forwarded");
                p_we_gate_r5: assert ((sel[g] != SEL_NEAR || near_wr_i) &&
                                      (sel[g] != SEL_FAR  || far_wr_i))
                    else $error("non-writing producer forwarded");
                p_file_data_r6: assert (sel[g] != SEL_FILE || opnd[g] == file[g])
                    else $error("file select without file data");
            end
        end
    end

    assign op_a_sel_o = sel[0];
    assign op_b_sel_o = sel[1];
    assign op_a_o     = opnd[0];
    assign op_b_o     = opnd[1];

    always_comb begin
        if (!$isunknown({op_a_src_i, op_b_src_i, near_dst_i, near_wr_i, far_dst_i, far_wr_i})) begin
            p_same_src_r7: assert (op_a_src_i != op_b_src_i || op_a_sel_o == op_b_sel_o)
                else $error("same source decided differently");
        end
    end
endmodule

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [RW-1:0] a_src, b_src, n_dst, f_dst;
    logic [DW-1:0] a_file, b_file, n_val, f_val;
    logic          n_wr, f_wr;
    logic [1:0]    a_sel, b_sel;
    logic [DW-1:0] a_out, b_out;

    fwd_unit #(.RW(RW), .DW(DW)) u0 (
        .op_a_src_i (a_src), .op_b_src_i (b_src),
        .op_a_file_i(a_file), .op_b_file_i(b_file),
        .near_dst_i (n_dst), .near_wr_i (n_wr), .near_val_i (n_val),
        .far_dst_i  (f_dst), .far_wr_i  (f_wr), .far_val_i  (f_val),
        .op_a_sel_o (a_sel), .op_b_sel_o (b_sel),
        .op_a_o     (a_out), .op_b_o     (b_out)
    );

    typedef struct {
        bit        wr;
        bit [4:0]  sa, sb, dst;
        bit [31:0] res;
    } slot_t;

    int        n_chk = 0;
    int        n_bad = 0;
    bit        done  = 0;
    bit [31:0] rf   [32];   // physical file: written when an instruction retires
    bit [31:0] arch [32];   // architectural view: updated as soon as a result exists
    slot_t     ex_s, near_s, far_s;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // newest in-flight writer of s decides the source
    function automatic bit [1:0] want_sel(bit [4:0] s);
        if (s == 0) return 2'b00;
        if (near_s.wr && near_s.dst == s) return 2'b10;
        if (far_s.wr && far_s.dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string req_of(bit [4:0] s, bit [1:0] e);
        if (e == 2'b10 && far_s.wr && far_s.dst == s) return "R3";
        if (e == 2'b10) return "R1";
        if (e == 2'b01) return "R2";
        if (s == 0 && ((near_s.wr && near_s.dst == 0) || (far_s.wr && far_s.dst == 0))) return "R4";
        if (s != 0 && ((!near_s.wr && near_s.dst == s) || (!far_s.wr && far_s.dst == s))) return "R5";
        return "R6";
    endfunction

    task automatic step(bit wr, bit [4:0] dst, bit [4:0] sa, bit [4:0] sb);
        bit [31:0] ea, eb;
        bit [1:0]  sel_a, sel_b;
        string     ra, rb;
        @(negedge clk);
        if (far_s.wr && far_s.dst != 0) rf[far_s.dst] = far_s.res;
        far_s  = near_s;
        near_s = ex_s;
        ex_s   = '{wr: wr, sa: sa, sb: sb, dst: dst, res: 32'h0};
        a_src = sa;          b_src = sb;
        a_file = rf[sa];     b_file = rf[sb];
        n_dst = near_s.dst;  n_wr = near_s.wr;  n_val = near_s.res;
        f_dst = far_s.dst;   f_wr = far_s.wr;   f_val = far_s.res;
        #1;
        ea = arch[sa];  eb = arch[sb];
        sel_a = want_sel(sa);  sel_b = want_sel(sb);
        ra = req_of(sa, sel_a); rb = req_of(sb, sel_b);
        chk(a_sel == sel_a, ra, "select A", a_sel, sel_a);
        chk(a_out == ea,    ra, "operand A", a_out, ea);
        chk(b_sel == sel_b, rb, "select B", b_sel, sel_b);
        chk(b_out == eb,    rb, "operand B", b_out, eb);
        chk(a_sel != 2'b11 && b_sel != 2'b11, "R8", "reserved code", {a_sel, b_sel}, 0);
        if (sa == sb) begin
            chk(a_sel == b_sel && a_out == b_out, "R7", "same source A/B", {a_sel, a_out}, {b_sel, b_out});
        end
        ex_s.res = ea + eb + 32'd1;
        if (wr && dst != 0) arch[dst] = ex_s.res;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            rf[i]   = (i == 0) ? 32'h0 : 32'h1000 * i + 32'd7;
            arch[i] = rf[i];
        end
        ex_s = '{wr: 0, sa: 0, sb: 0, dst: 0, res: 0};
        near_s = ex_s;
        far_s  = ex_s;

        step(0, 0, 3, 5);                          // R6 idle pipeline (reset state)
        step(0, 0, 0, 0);
        // R3: three dependent adds on one register
        step(1, 1, 1, 2);
        step(1, 1, 1, 3);
        step(1, 1, 1, 4);
        // R2: far only, bubble in between, both operands the same (R7)
        step(1, 6, 2, 3);
        step(0, 0, 0, 0);
        step(1, 7, 6, 6);
        // R4: producers writing register zero
        step(1, 0, 1, 1);
        step(1, 0, 2, 2);
        step(1, 8, 0, 0);
        // R5: matching producers with write-enable low
        step(0, 9, 1, 1);
        step(0, 9, 2, 2);
        step(1, 10, 9, 9);
        // R7: operand A from far stage, B from near stage
        step(1, 11, 2, 3);
        step(1, 12, 4, 5);
        step(1, 13, 11, 12);
        step(1, 14, 12, 11);

        for (int k = 0; k < 600; k++) begin
            step(1'($urandom_range(0, 3) != 0), 5'($urandom_range(0, 7)),
                 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule